// File: doc/BRIEF.md
# Step attenuator control latch

This block is the digital control core of a four-bit step attenuator with 3 dB steps. Four active-low control bits set the attenuation. Each bit carries a binary weight: bit 0 is 3 dB, bit 1 is 6 dB, bit 2 is 12 dB and bit 3 is 24 dB. The total attenuation is the sum of the weights of every bit driven low. A hold-enable input picks between two modes. When it is high, the held state tracks the control bits. When it is low, the held state is frozen, so a new word can be set up and then pulsed in. A serial-select input is used only to qualify parallel operation: while it is high, the held state does not move.

After reset the block forces the highest attenuation (45 dB) for a programmable settling period. When that period ends it commits a start-up state, chosen by the level of hold-enable. If hold-enable is low, the start-up state comes from two preset pins. If hold-enable is high, it is copied from the control bits. Every input passes through a two-flop synchroniser first. The block outputs the held active-low word, the same setting in 3 dB units, and the setting in dB.

Top module: `step_atten_ctl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `atten_state` is 4'b0000, `atten_steps` is 15 and `atten_db` is 45.
- R2: For the first SETTLE_CYCLES-1 rising edges after `rst` falls, the outputs stay at 45 dB. During this time `ctl_n` and the preset pins have no effect.
- R3: On the SETTLE_CYCLES-th rising edge after reset, if the synchronised `hold_en` is low, the block loads a preset. With `preset_a`=1 and `preset_b`=1 it loads 4'b1111 (0 dB). Every other preset combination loads 4'b0000 (45 dB).
- R4: On that same edge, if the synchronised `hold_en` is high, `atten_state` takes the synchronised `ctl_n`.
- R5: Bit i of `ctl_n` is active-low and weighs 3·2^i dB. `atten_steps` equals the bitwise inverse of `atten_state`, and `atten_db` equals 3·`atten_steps`.
- R6: After start-up, while `hold_en` is high and `ser_sel` is low, `atten_state` takes `ctl_n` on the third rising edge after the inputs change.
- R7: After start-up, while `hold_en` is low, `atten_state` holds whatever `ctl_n` does.
- R8: While `ser_sel` is high, `atten_state` holds whatever `ctl_n` and `hold_en` do.
- R9: An input change is not visible at the outputs after only two rising edges.
- R10: If the word is set up while `hold_en` is low, then `hold_en` is pulsed high, then `ctl_n` changes in the same cycle that `hold_en` falls, the pulsed word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the settling sequence |
| ctl_n | input | 4 | Active-low attenuation control bits |
| hold_en | input | 1 | High: transparent; low: hold; also selects the start-up source |
| ser_sel | input | 1 | High freezes the held state; low allows parallel control |
| preset_a | input | 1 | Start-up preset pin A |
| preset_b | input | 1 | Start-up preset pin B |
| atten_state | output | 4 | Held active-low control word |
| atten_steps | output | 4 | Attenuation in 3 dB units (0 to 15) |
| atten_db | output | 6 | Attenuation in dB (0 to 45) |

## Verification
In normal operation, an input change appears at the outputs on the third rising edge: two synchroniser flops and then the held register. The bench drives inputs on falling edges and samples on the falling edge after the third rising edge. Where the value should change, it also samples after the second rising edge to confirm the old value is still there. The start-up commit lands exactly SETTLE_CYCLES rising edges after reset falls, so the bench checks 45 dB at every falling edge before that and checks the committed state at the falling edge after it.

// File: rtl/atten_pkg.sv
`timescale 1ns/1ps
package atten_pkg;
  typedef enum logic {PH_SETTLE = 1'b0, PH_RUN = 1'b1} phase_e;

  function automatic logic preset_bypass(input logic a, input logic b);
    return a & b;
  endfunction
endpackage

// File: rtl/atten_sync.sv
`timescale 1ns/1ps
module atten_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/atten_settle.sv
`timescale 1ns/1ps
module atten_settle
  import atten_pkg::*;
#(
  parameter int CTRL_BITS     = 4,
  parameter int SETTLE_CYCLES = 40_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_s,
  input  logic                 pa_s,
  input  logic                 pb_s,
  input  logic [CTRL_BITS-1:0] ctl_s,
  output logic                 run,
  output logic                 load,
  output logic [CTRL_BITS-1:0] load_val
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  phase_e        phase;
  logic [CW-1:0] cnt;

  assign load = (phase == PH_SETTLE) && (cnt == LAST);
  assign run  = (phase == PH_RUN);

  always_comb begin
    if (en_s)                        load_val = ctl_s;
    else if (preset_bypass(pa_s, pb_s)) load_val = '1;
    else                             load_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_SETTLE;
      cnt   <= '0;
    end else if (load) begin
      phase <= PH_RUN;
    end else if (phase == PH_SETTLE) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SETTLE && !load) |=> (phase == PH_SETTLE && cnt == $past(cnt) + 1'b1));
  a_r3_load_once: assert property (@(posedge clk) disable iff (rst)
    load |=> (run && !load));
  a_r2_run_sticky: assert property (@(posedge clk) disable iff (rst)
    run |=> run);
endmodule

// File: rtl/atten_hold.sv
`timescale 1ns/1ps
module atten_hold #(
  parameter int CTRL_BITS = 4,
  parameter int STEP_DB   = 3,
  parameter int DBW       = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 load,
  input  logic [CTRL_BITS-1:0] load_val,
  input  logic                 en_s,
  input  logic                 ser_s,
  input  logic [CTRL_BITS-1:0] ctl_s,
  output logic [CTRL_BITS-1:0] state,
  output logic [CTRL_BITS-1:0] steps,
  output logic [DBW-1:0]       db
);
  localparam logic [DBW-1:0] DB_MAX = DBW'(STEP_DB * (2**CTRL_BITS - 1));

  logic [CTRL_BITS-1:0] nxt;
  logic [CTRL_BITS-1:0] nxt_steps;

  always_comb begin
    if (load)                     nxt = load_val;
    else if (run && en_s && !ser_s) nxt = ctl_s;
    else                          nxt = state;
    nxt_steps = ~nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
      steps <= '1;
      db    <= DB_MAX;
    end else begin
      state <= nxt;
      steps <= nxt_steps;
      db    <= DBW'(nxt_steps) * DBW'(STEP_DB);
    end
  end

  a_r2_settle_floor: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> (state == '0));
  a_r6_follow: assert property (@(posedge clk) disable iff (rst)
    (run && !load && en_s && !ser_s) |=> (state == $past(ctl_s)));
  a_r7_hold_latched: assert property (@(posedge clk) disable iff (rst)
    (run && !load && !en_s) |=> $stable(state));
  a_r8_freeze_serial: assert property (@(posedge clk) disable iff (rst)
    (run && !load && ser_s) |=> $stable(state));
  a_r5_steps_inverse: assert property (@(posedge clk) disable iff (rst)
    steps == ~state);
  a_r5_db_scale: assert property (@(posedge clk) disable iff (rst)
    db == DBW'(steps) * DBW'(STEP_DB));
endmodule

// File: rtl/step_atten_ctl.sv
`timescale 1ns/1ps
module step_atten_ctl #(
  parameter int CTRL_BITS     = 4,
  parameter int STEP_DB       = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 40_000_000,
  parameter int DBW           = $clog2(STEP_DB * (2**CTRL_BITS - 1) + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CTRL_BITS-1:0] ctl_n,
  input  logic                 hold_en,
  input  logic                 ser_sel,
  input  logic                 preset_a,
  input  logic                 preset_b,
  output logic [CTRL_BITS-1:0] atten_state,
  output logic [CTRL_BITS-1:0] atten_steps,
  output logic [DBW-1:0]       atten_db
);
  localparam int SW = CTRL_BITS + 4;

  logic [SW-1:0]        raw_bus, sync_bus;
  logic [CTRL_BITS-1:0] ctl_s, load_val;
  logic                 en_s, ser_s, pa_s, pb_s, run, load;

  assign raw_bus = {ctl_n, hold_en, ser_sel, preset_a, preset_b};
  assign {ctl_s, en_s, ser_s, pa_s, pb_s} = sync_bus;

  atten_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(raw_bus), .dout(sync_bus)
  );

  atten_settle #(.CTRL_BITS(CTRL_BITS), .SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst(rst), .en_s(en_s), .pa_s(pa_s), .pb_s(pb_s), .ctl_s(ctl_s),
    .run(run), .load(load), .load_val(load_val)
  );

  atten_hold #(.CTRL_BITS(CTRL_BITS), .STEP_DB(STEP_DB), .DBW(DBW)) u_hold (
    .clk(clk), .rst(rst), .run(run), .load(load), .load_val(load_val),
    .en_s(en_s), .ser_s(ser_s), .ctl_s(ctl_s),
    .state(atten_state), .steps(atten_steps), .db(atten_db)
  );

  a_r3_preset_commit: assert property (@(posedge clk) disable iff (rst)
    (load && !en_s) |=> (atten_state == ((pa_s & pb_s) ? '1 : '0)));
  a_r4_data_commit: assert property (@(posedge clk) disable iff (rst)
    (load && en_s) |=> (atten_state == $past(ctl_s)));
endmodule

// File: tb/sim_step_atten_ctl.sv
`timescale 1ns/1ps
module sim_step_atten_ctl;
  localparam int S = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ctl_n = 4'hF;
  logic       hold_en = 1'b0, ser_sel = 1'b0, preset_a = 1'b0, preset_b = 1'b0;
  logic [3:0] atten_state, atten_steps;
  logic [5:0] atten_db;

  int checks = 0, errors = 0;
  logic [3:0] exp_st = 4'h0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  step_atten_ctl #(.SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rst(rst), .ctl_n(ctl_n), .hold_en(hold_en), .ser_sel(ser_sel),
    .preset_a(preset_a), .preset_b(preset_b),
    .atten_state(atten_state), .atten_steps(atten_steps), .atten_db(atten_db)
  );

  function automatic int db_of(input logic [3:0] st);
    int d = 0;
    for (int i = 0; i < 4; i++) if (!st[i]) d += 3 * (1 << i);
    return d;
  endfunction

  task automatic chk(input string tag, input logic [3:0] e);
    checks++;
    if (atten_state !== e || int'(atten_steps) != db_of(e) / 3 || int'(atten_db) != db_of(e)) begin
      errors++;
      $display("FAIL %s: state=%b steps=%0d db=%0d expected state=%b steps=%0d db=%0d",
               tag, atten_state, atten_steps, atten_db, e, db_of(e) / 3, db_of(e));
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic apply(input logic [3:0] c, input logic e, input logic s, input string tag);
    logic [3:0] nxt;
    ctl_n = c; hold_en = e; ser_sel = s;
    nxt = (!s && e) ? c : exp_st;
    step(); step();
    if (nxt != exp_st) chk("R9", exp_st);
    step();
    exp_st = nxt;
    if (tag != "") chk(tag, exp_st);
    else if (s)    chk("R8", exp_st);
    else if (!e)   chk("R7", exp_st);
    else           chk("R6", exp_st);
  endtask

  task automatic pwr(input logic e, input logic a, input logic b, input logic [3:0] c, input string tag);
    rst = 1'b1; hold_en = e; preset_a = a; preset_b = b; ctl_n = c; ser_sel = 1'b0;
    step(); step(); step();
    chk("R1", 4'h0);
    rst = 1'b0;
    for (int k = 1; k < S; k++) begin
      step();
      chk("R2", 4'h0);
      if (!e) ctl_n = 4'($urandom);
    end
    step();
    exp_st = e ? c : ((a & b) ? 4'hF : 4'h0);
    chk(tag, exp_st);
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    pwr(1'b0, 1'b0, 1'b0, 4'h5, "R3");
    pwr(1'b0, 1'b1, 1'b0, 4'h5, "R3");
    pwr(1'b0, 1'b0, 1'b1, 4'h5, "R3");
    pwr(1'b0, 1'b1, 1'b1, 4'h0, "R3");
    apply(4'h3, 1'b0, 1'b0, "R7");
    pwr(1'b1, 1'b0, 1'b0, 4'b1010, "R4");
    // R5 single-bit weights and extremes
    apply(4'b1110, 1'b1, 1'b0, "R5");
    apply(4'b1101, 1'b1, 1'b0, "R5");
    apply(4'b1011, 1'b1, 1'b0, "R5");
    apply(4'b0111, 1'b1, 1'b0, "R5");
    apply(4'b0000, 1'b1, 1'b0, "R5");
    apply(4'b1111, 1'b1, 1'b0, "R5");
    // R10 latched pulse: set up low, pulse high, change data as enable falls
    apply(4'b0110, 1'b0, 1'b0, "R7");
    apply(4'b0110, 1'b1, 1'b0, "R6");
    apply(4'b1001, 1'b0, 1'b0, "R10");
    apply(4'b0001, 1'b0, 1'b0, "R10");
    // R8 serial select freezes even with enable high
    apply(4'b1100, 1'b1, 1'b1, "R8");
    apply(4'b0011, 1'b1, 1'b1, "R8");
    apply(4'b0011, 1'b1, 1'b0, "R6");
    for (int n = 0; n < 300; n++)
      apply(4'($urandom), 1'($urandom), ($urandom % 4) == 0, "");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule